// File: doc/BRIEF.md
# Multithreaded DFA Pattern Walker

This block runs multi-pattern matching by walking a deterministic finite automaton graph over the bytes of a packet payload. A submitter hands in a job (an identifier, a graph start node, a payload buffer base, a byte length and a stop mode). It then carries on with other work while the engine walks the graph. Sixteen independent walker contexts run at the same time. Each context has at most one node read in flight, because the next node address depends on the node word just read and on the next payload byte.

Graph storage sits behind two low-latency read channels with a fixed latency, chosen by the low bit of the node address. Each channel returns its responses in request order. The engine keeps a per-channel queue of thread numbers, so every returned node word reaches the context that asked for it. While one thread waits for its read, reads from other threads fill the latency gap. A node word carries a match flag in its top bit and a next-node base address in the remaining bits. The next address is that base plus the payload byte, wrapping at the address width.

When a walk ends, the engine posts a completion record on an output queue as a new work item. The record holds the job identifier, a match-found bit and the number of payload bytes consumed. Job intake and result posting are valid/ready streams. A job is taken on a cycle where `job_valid` and `job_ready` are both high. `job_ready` falls while every context is busy. A result is held, unchanged, while `res_valid` is high and `res_ready` is low. Payload bytes come from a combinational read port that answers in the same cycle.

Top module: `dfa_walker`

## Requirements
- R1: After reset `job_ready` is 1, `res_valid` is 0 and neither memory channel issues a request.
- R2: A node word is {match flag in bit AW, next base in bits AW-1:0}. After byte k of the payload (read at buffer base + k), the next node address is base + byte, modulo 2^AW.
- R3: In full mode (`job_first`=0), a job of length L reads exactly L+1 nodes, starting at the start node. It reports count L, and its match bit is the OR of the flags of every node it visited.
- R4: In first-match mode (`job_first`=1), the walk stops at the first visited node whose flag is set. The count is the number of bytes consumed to reach that node, and the match bit is 1. If no node is flagged, the walk behaves as in R3 and reports match 0.
- R5: A node read for address A goes out on channel A[0]. Each job has at most one node read outstanding at a time.
- R6: There are 16 walker contexts. A job is accepted on `job_valid && job_ready`. `job_ready` is 0 exactly when all 16 contexts hold unposted jobs.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_id`, `res_match` and `res_count` keep their values.
- R8: Node responses on each channel are paired, in order, with the requests on that channel.
- R9: A job of length 0 reads only its start node, reports count 0, and reports the start node's flag as its match bit.
- R10: Every accepted job produces exactly one completion record carrying its own identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | A free walker context exists |
| job_id | input | IDW | Job identifier returned in the result |
| job_start | input | AW | Graph start node address |
| job_buf | input | BAW | Payload buffer base address |
| job_len | input | LW | Payload length in bytes |
| job_first | input | 1 | 1: stop at first flagged node; 0: walk whole payload |
| pay_rd_addr | output | BAW | Payload byte address |
| pay_rd_data | input | 8 | Payload byte at `pay_rd_addr`, same cycle |
| mem_req_valid | output | 2 | Node read request, one bit per channel |
| mem_req_addr | output | 2*AW | Node address per channel (channel c in bits c*AW +: AW) |
| mem_rsp_valid | input | 2 | Node word returned, per channel |
| mem_rsp_data | input | 2*(AW+1) | Node word per channel (channel c in bits c*(AW+1) +: AW+1) |
| res_valid | output | 1 | Completion record available |
| res_ready | input | 1 | Completion record taken |
| res_id | output | IDW | Identifier of the finished job |
| res_match | output | 1 | A match was found |
| res_count | output | LW | Payload bytes consumed |

## Verification
The assertions assume that the graph memory gives exactly one response per request on the same channel, in request order. They also assume that a response never comes back on a channel with no read in flight. The bench's memory model is a fixed three-stage delay line per channel, so it meets these assumptions by design. The payload port is assumed to answer combinationally. The bench computes every byte with a pure function of the address. Jobs are offered only through the valid/ready handshake, and `res_ready` changes only well after a clock edge. This keeps the stability property on held results from depending on process order.

// File: rtl/dfa_walk_pkg.sv
package dfa_walk_pkg;
  localparam int NCH = 2;

  typedef enum logic [2:0] {
    TH_IDLE,
    TH_ISSUE,
    TH_WAIT,
    TH_PAY,
    TH_DONE
  } th_state_e;
endpackage

// File: rtl/dfa_rr_arb.sv
module dfa_rr_arb #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt,
  output logic         any
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] win;

  always_comb begin
    int idx;
    gnt = '0;
    any = 1'b0;
    win = '0;
    for (int i = 0; i < N; i++) begin
      idx = int'(ptr_q) + i;
      if (idx >= N) idx = idx - N;
      if (!any && req[idx]) begin
        gnt[idx] = 1'b1;
        any      = 1'b1;
        win      = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv && any) begin
      if (int'(win) == N - 1) ptr_q <= '0;
      else                    ptr_q <= win + 1'b1;
    end
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
endmodule

// File: rtl/dfa_tag_fifo.sv
module dfa_tag_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty
);
  localparam int AWD = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]   mem_q [DEPTH];
  logic [AWD-1:0] wr_q, rd_q;
  logic [AWD:0]   cnt_q;
  logic           full;

  assign empty    = (cnt_q == '0);
  assign full     = (int'(cnt_q) == DEPTH);
  assign pop_data = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) begin
        mem_q[wr_q] <= push_data;
        wr_q <= (int'(wr_q) == DEPTH - 1) ? '0 : wr_q + 1'b1;
      end
      if (pop) rd_q <= (int'(rd_q) == DEPTH - 1) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + {{AWD{1'b0}}, push} - {{AWD{1'b0}}, pop};
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dfa_thread_ctx.sv
module dfa_thread_ctx
  import dfa_walk_pkg::*;
#(
  parameter int AW  = 12,
  parameter int BAW = 12,
  parameter int LW  = 8,
  parameter int IDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc,
  input  logic [IDW-1:0] job_id,
  input  logic [AW-1:0]  job_start,
  input  logic [BAW-1:0] job_buf,
  input  logic [LW-1:0]  job_len,
  input  logic           job_first,
  input  logic           pay_gnt,
  input  logic [7:0]     pay_byte,
  input  logic           issue_gnt,
  input  logic           rsp_hit,
  input  logic [AW:0]    rsp_word,
  input  logic           post_gnt,
  output logic           is_idle,
  output logic           is_done,
  output logic           want_issue,
  output logic [AW-1:0]  node_addr,
  output logic           want_pay,
  output logic [BAW-1:0] pay_addr,
  output logic [IDW-1:0] res_id,
  output logic           res_match,
  output logic [LW-1:0]  res_count
);
  th_state_e      st_q;
  logic [IDW-1:0] id_q;
  logic [AW-1:0]  node_q, base_q;
  logic [BAW-1:0] buf_q;
  logic [LW-1:0]  len_q, pos_q;
  logic           first_q, match_q;
  logic           flag_in, stop_now;

  assign flag_in  = rsp_word[AW];
  assign stop_now = (first_q && flag_in) || (pos_q == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= TH_IDLE;
      id_q    <= '0;
      node_q  <= '0;
      base_q  <= '0;
      buf_q   <= '0;
      len_q   <= '0;
      pos_q   <= '0;
      first_q <= 1'b0;
      match_q <= 1'b0;
    end else begin
      unique case (st_q)
        TH_IDLE: if (alloc) begin
          id_q    <= job_id;
          node_q  <= job_start;
          buf_q   <= job_buf;
          len_q   <= job_len;
          first_q <= job_first;
          pos_q   <= '0;
          match_q <= 1'b0;
          st_q    <= TH_ISSUE;
        end
        TH_ISSUE: if (issue_gnt) st_q <= TH_WAIT;
        TH_WAIT: if (rsp_hit) begin
          match_q <= match_q | flag_in;
          base_q  <= rsp_word[AW-1:0];
          st_q    <= stop_now ? TH_DONE : TH_PAY;
        end
        TH_PAY: if (pay_gnt) begin
          node_q <= base_q + AW'(pay_byte);
          pos_q  <= pos_q + 1'b1;
          st_q   <= TH_ISSUE;
        end
        TH_DONE: if (post_gnt) st_q <= TH_IDLE;
        default: st_q <= TH_IDLE;
      endcase
    end
  end

  assign is_idle    = (st_q == TH_IDLE);
  assign is_done    = (st_q == TH_DONE);
  assign want_issue = (st_q == TH_ISSUE);
  assign want_pay   = (st_q == TH_PAY);
  assign node_addr  = node_q;
  assign pay_addr   = buf_q + BAW'(pos_q);
  assign res_id     = id_q;
  assign res_match  = match_q;
  assign res_count  = pos_q;

  // R5
  issue_in_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_gnt |-> (st_q == TH_ISSUE));
  // R8
  rsp_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (st_q == TH_WAIT));
  // R3
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != TH_IDLE) |-> (pos_q <= len_q));
endmodule

// File: rtl/dfa_walker.sv
module dfa_walker
  import dfa_walk_pkg::*;
#(
  parameter int NTHR = 16,
  parameter int AW   = 12,
  parameter int BAW  = 12,
  parameter int LW   = 8,
  parameter int IDW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  job_valid,
  output logic                  job_ready,
  input  logic [IDW-1:0]        job_id,
  input  logic [AW-1:0]         job_start,
  input  logic [BAW-1:0]        job_buf,
  input  logic [LW-1:0]         job_len,
  input  logic                  job_first,
  output logic [BAW-1:0]        pay_rd_addr,
  input  logic [7:0]            pay_rd_data,
  output logic [1:0]            mem_req_valid,
  output logic [2*AW-1:0]       mem_req_addr,
  input  logic [1:0]            mem_rsp_valid,
  input  logic [2*(AW+1)-1:0]   mem_rsp_data,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [IDW-1:0]        res_id,
  output logic                  res_match,
  output logic [LW-1:0]         res_count
);
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1;
  localparam int NW = AW + 1;

  logic [NTHR-1:0] th_idle, th_done, th_want_issue, th_want_pay;
  logic [NTHR-1:0] th_alloc, th_rsp_hit, pay_gnt, post_gnt;
  logic [AW-1:0]   th_node [NTHR];
  logic [BAW-1:0]  th_pay  [NTHR];
  logic [IDW-1:0]  th_id   [NTHR];
  logic            th_match [NTHR];
  logic [LW-1:0]   th_cnt  [NTHR];
  logic [NW-1:0]   th_rsp_word [NTHR];

  // ---------------- intake: lowest free context ----------------
  always_comb begin
    logic found;
    found    = 1'b0;
    th_alloc = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (!found && th_idle[t]) begin
        found       = 1'b1;
        th_alloc[t] = job_valid;
      end
    end
  end
  assign job_ready = |th_idle;

  // ---------------- payload port arbitration ----------------
  logic pay_any;
  dfa_rr_arb #(.N(NTHR)) u_pay_arb (
    .clk(clk), .rst_n(rst_n), .req(th_want_pay), .adv(1'b1),
    .gnt(pay_gnt), .any(pay_any)
  );

  always_comb begin
    pay_rd_addr = '0;
    for (int t = 0; t < NTHR; t++)
      if (pay_gnt[t]) pay_rd_addr = th_pay[t];
  end

  // ---------------- per-channel issue and response pairing ----------------
  logic [NTHR-1:0] iss_gnt [NCH];
  logic [TW-1:0]   tag_out [NCH];
  logic [NW-1:0]   ch_word [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NTHR-1:0] ch_req;
    logic            ch_any;
    logic [TW-1:0]   ch_tag;
    logic [AW-1:0]   ch_addr;
    logic            tag_empty;

    always_comb begin
      for (int t = 0; t < NTHR; t++)
        ch_req[t] = th_want_issue[t] && (th_node[t][0] == 1'(c));
    end

    dfa_rr_arb #(.N(NTHR)) u_iss_arb (
      .clk(clk), .rst_n(rst_n), .req(ch_req), .adv(1'b1),
      .gnt(iss_gnt[c]), .any(ch_any)
    );

    always_comb begin
      ch_tag  = '0;
      ch_addr = '0;
      for (int t = 0; t < NTHR; t++) begin
        if (iss_gnt[c][t]) begin
          ch_tag  = TW'(t);
          ch_addr = th_node[t];
        end
      end
    end

    dfa_tag_fifo #(.DEPTH(NTHR), .W(TW)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .push(ch_any), .push_data(ch_tag),
      .pop(mem_rsp_valid[c]), .pop_data(tag_out[c]),
      .empty(tag_empty)
    );

    assign mem_req_valid[c]            = ch_any;
    assign mem_req_addr[c*AW +: AW]    = ch_addr;
    assign ch_word[c]                  = mem_rsp_data[c*NW +: NW];

    // R5
    req_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid[c] |-> (mem_req_addr[c*AW] == 1'(c)));
    // R8
    rsp_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid[c] |-> !tag_empty);
  end

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      th_rsp_hit[t]  = 1'b0;
      th_rsp_word[t] = '0;
      for (int c = 0; c < NCH; c++) begin
        if (mem_rsp_valid[c] && (tag_out[c] == TW'(t))) begin
          th_rsp_hit[t]  = 1'b1;
          th_rsp_word[t] = ch_word[c];
        end
      end
    end
  end

  // ---------------- walker contexts ----------------
  for (genvar t = 0; t < NTHR; t++) begin : g_th
    logic issue_g;
    always_comb begin
      issue_g = 1'b0;
      for (int c = 0; c < NCH; c++) issue_g = issue_g | iss_gnt[c][t];
    end

    dfa_thread_ctx #(.AW(AW), .BAW(BAW), .LW(LW), .IDW(IDW)) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .alloc(th_alloc[t]),
      .job_id(job_id), .job_start(job_start), .job_buf(job_buf),
      .job_len(job_len), .job_first(job_first),
      .pay_gnt(pay_gnt[t]), .pay_byte(pay_rd_data),
      .issue_gnt(issue_g),
      .rsp_hit(th_rsp_hit[t]), .rsp_word(th_rsp_word[t]),
      .post_gnt(post_gnt[t]),
      .is_idle(th_idle[t]), .is_done(th_done[t]),
      .want_issue(th_want_issue[t]), .node_addr(th_node[t]),
      .want_pay(th_want_pay[t]), .pay_addr(th_pay[t]),
      .res_id(th_id[t]), .res_match(th_match[t]), .res_count(th_cnt[t])
    );
  end

  // ---------------- completion posting ----------------
  logic [NTHR-1:0] done_gnt;
  logic            done_any, load;
  logic            out_v_q, out_m_q;
  logic [IDW-1:0]  out_id_q;
  logic [LW-1:0]   out_c_q;

  assign load = done_any && (!out_v_q || res_ready);

  dfa_rr_arb #(.N(NTHR)) u_post_arb (
    .clk(clk), .rst_n(rst_n), .req(th_done), .adv(load),
    .gnt(done_gnt), .any(done_any)
  );

  assign post_gnt = load ? done_gnt : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v_q  <= 1'b0;
      out_m_q  <= 1'b0;
      out_id_q <= '0;
      out_c_q  <= '0;
    end else if (load) begin
      out_v_q <= 1'b1;
      for (int t = 0; t < NTHR; t++) begin
        if (done_gnt[t]) begin
          out_id_q <= th_id[t];
          out_m_q  <= th_match[t];
          out_c_q  <= th_cnt[t];
        end
      end
    end else if (res_ready) begin
      out_v_q <= 1'b0;
    end
  end

  assign res_valid = out_v_q;
  assign res_id    = out_id_q;
  assign res_match = out_m_q;
  assign res_count = out_c_q;

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_id) &&
                                   $stable(res_match) && $stable(res_count)));
  // R6
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && job_ready && !load) |=> ($countones(th_idle) ==
                                           $countones($past(th_idle)) - 1));
endmodule

// File: tb/dfa_walker_tb.sv
module dfa_walker_tb;
  localparam int AW  = 12;
  localparam int BAW = 12;
  localparam int LW  = 8;
  localparam int IDW = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                job_valid = 1'b0, job_first = 1'b0, res_ready = 1'b0;
  logic                job_ready;
  logic [IDW-1:0]      job_id = '0;
  logic [AW-1:0]       job_start = '0;
  logic [BAW-1:0]      job_buf = '0;
  logic [LW-1:0]       job_len = '0;
  logic [BAW-1:0]      pay_rd_addr;
  logic [7:0]          pay_rd_data;
  logic [1:0]          mem_req_valid, mem_rsp_valid;
  logic [2*AW-1:0]     mem_req_addr;
  logic [2*(AW+1)-1:0] mem_rsp_data;
  logic                res_valid, res_match;
  logic [IDW-1:0]      res_id;
  logic [LW-1:0]       res_count;

  dfa_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .job_valid(job_valid), .job_ready(job_ready), .job_id(job_id),
    .job_start(job_start), .job_buf(job_buf), .job_len(job_len),
    .job_first(job_first),
    .pay_rd_addr(pay_rd_addr), .pay_rd_data(pay_rd_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_id(res_id),
    .res_match(res_match), .res_count(res_count)
  );

  // ---- graph and payload models (R2 word layout: flag at bit AW) ----
  function automatic logic node_flag(logic [AW-1:0] a);
    return a[2:0] == 3'd5;
  endfunction
  function automatic logic [AW-1:0] node_base(logic [AW-1:0] a);
    return AW'(a * 12'd73 + 12'd19);
  endfunction
  function automatic logic [7:0] pay_byte(logic [BAW-1:0] x);
    return 8'(x * 12'd31 + (x >> 4));
  endfunction

  assign pay_rd_data = pay_byte(pay_rd_addr);

  logic [LAT-1:0] vpipe [2];
  logic [AW:0]    dpipe [2][LAT];
  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      vpipe[c] <= rst_n ? {vpipe[c][LAT-2:0], mem_req_valid[c]} : '0;
      dpipe[c][0] <= {node_flag(mem_req_addr[c*AW +: AW]),
                      node_base(mem_req_addr[c*AW +: AW])};
      for (int k = 1; k < LAT; k++) dpipe[c][k] <= dpipe[c][k-1];
    end
  end
  for (genvar c = 0; c < 2; c++) begin : g_mem
    assign mem_rsp_valid[c] = vpipe[c][LAT-1];
    assign mem_rsp_data[c*(AW+1) +: AW+1] = dpipe[c][LAT-1];
  end

  // ---- bookkeeping ----
  int n_chk = 0, n_err = 0;
  int n_res = 0, n_reads = 0, chan_bad = 0, dup_bad = 0;
  logic       exp_m [256];
  logic [7:0] exp_c [256];
  logic       got   [256];
  logic       got_m [256];
  logic [7:0] got_c [256];
  int         exp_reads = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (mem_req_valid[c]) begin
          n_reads++;
          if (mem_req_addr[c*AW] != 1'(c)) chan_bad++;
        end
      end
      if (res_valid && res_ready) begin
        if (got[res_id]) dup_bad++;
        got[res_id]   = 1'b1;
        got_m[res_id] = res_match;
        got_c[res_id] = res_count;
        n_res++;
      end
    end
  end

  // Bench model of a walk (R2, R3, R4, R9)
  task automatic model(input logic [AW-1:0] s, input logic [BAW-1:0] b,
                       input logic [LW-1:0] l, input logic f,
                       output logic m, output logic [7:0] cnt);
    logic [AW-1:0] a;
    a = s; m = node_flag(a); cnt = 0;
    while (!(f && node_flag(a)) && cnt < l) begin
      a = node_base(a) + AW'(pay_byte(b + BAW'(cnt)));
      cnt++;
      m = m | node_flag(a);
    end
  endtask

  task automatic submit(input int id, input logic [AW-1:0] s,
                        input logic [BAW-1:0] b, input logic [LW-1:0] l,
                        input logic f);
    logic m;
    logic [7:0] c;
    model(s, b, l, f, m, c);
    exp_m[id] = m; exp_c[id] = c; got[id] = 1'b0;
    exp_reads += int'(c) + 1;
    @(negedge clk);
    job_id = IDW'(id); job_start = s; job_buf = b; job_len = l;
    job_first = f; job_valid = 1'b1;
    while (!job_ready) @(negedge clk);
    @(negedge clk);
    job_valid = 1'b0;
  endtask

  task automatic start_batch();
    @(negedge clk);
    n_res = 0; n_reads = 0; exp_reads = 0;
  endtask

  task automatic finish_batch(input int lo, input int hi, input string req);
    int waited = 0;
    while (n_res < hi - lo + 1 && waited < 20000) begin
      @(negedge clk); waited++;
    end
    repeat (LAT + 4) @(negedge clk);
    chk(n_res == hi - lo + 1, "R10", {req, " result count"}, n_res, hi - lo + 1);
    for (int id = lo; id <= hi; id++) begin
      chk(got[id], "R10", $sformatf("%s id %0d posted", req, id), int'(got[id]), 1);
      chk(got_m[id] == exp_m[id], req, $sformatf("id %0d match", id),
          int'(got_m[id]), int'(exp_m[id]));
      chk(got_c[id] == exp_c[id], req, $sformatf("id %0d count", id),
          int'(got_c[id]), int'(exp_c[id]));
    end
    chk(n_reads == exp_reads, req, "node reads issued (R3 one per step)",
        n_reads, exp_reads);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    @(negedge clk);
    chk(job_ready == 1'b1, "R1", "job_ready after reset", int'(job_ready), 1);
    chk(res_valid == 1'b0, "R1", "res_valid after reset", int'(res_valid), 0);
    chk(mem_req_valid == 2'b00, "R1", "no requests after reset",
        int'(mem_req_valid), 0);
  endtask

  task automatic t_single();
    start_batch();
    submit(1, 12'h123, 12'h040, 8'd1, 1'b0);   // R2 single transition
    submit(2, 12'h0a0, 12'h100, 8'd9, 1'b0);   // R3 full walk
    finish_batch(1, 2, "R3");
  endtask

  task automatic t_zero_len();
    start_batch();
    submit(3, 12'h005, 12'h000, 8'd0, 1'b0);   // R9 flagged start
    submit(4, 12'h010, 12'h000, 8'd0, 1'b0);   // R9 unflagged start
    submit(5, 12'h01d, 12'h000, 8'd0, 1'b1);   // R9 flagged start, first mode
    finish_batch(3, 5, "R9");
  endtask

  task automatic t_first_match();
    start_batch();
    for (int i = 0; i < 12; i++)
      submit(10 + i, AW'(i * 41 + 2), BAW'(i * 97), 8'd40, 1'b1);  // R4
    finish_batch(10, 21, "R4");
  endtask

  task automatic t_parallel();
    start_batch();
    for (int i = 0; i < 16; i++)
      submit(30 + i, AW'(i * 211 + 7), BAW'(i * 53), LW'(5 + i * 3), 1'b0);
    finish_batch(30, 45, "R3");
    chk(chan_bad == 0, "R5", "requests on wrong channel", chan_bad, 0);
  endtask

  task automatic t_backpressure();
    logic [IDW-1:0] h_id;
    logic           h_m;
    logic [LW-1:0]  h_c;
    start_batch();
    @(posedge clk); #2 res_ready = 1'b0;
    for (int i = 0; i < 16; i++)
      submit(60 + i, AW'(i * 17 + 300), BAW'(i * 11 + 500), 8'd60, 1'b0);
    chk(job_ready == 1'b0, "R6", "job_ready with 16 busy", int'(job_ready), 0);
    while (!res_valid) @(negedge clk);
    h_id = res_id; h_m = res_match; h_c = res_count;
    repeat (8) @(negedge clk);
    chk(res_valid == 1'b1, "R7", "valid held", int'(res_valid), 1);
    chk(res_id == h_id && res_match == h_m && res_count == h_c, "R7",
        "record held stable (id)", int'(res_id), int'(h_id));
    @(posedge clk); #2 res_ready = 1'b1;
    submit(76, 12'h777, 12'h321, 8'd12, 1'b0);
    finish_batch(60, 76, "R6");
  endtask

  task automatic t_dup();
    chk(dup_bad == 0, "R10", "duplicate results", dup_bad, 0);
  endtask

  // ---- main and watchdog ----
  bit finished = 1'b0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      got[i] = 1'b0; got_m[i] = 1'b0; got_c[i] = '0;
      exp_m[i] = 1'b0; exp_c[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2 res_ready = 1'b1;
    t_reset();
    t_single();
    t_zero_len();
    t_first_match();
    t_parallel();
    t_backpressure();
    t_dup();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule